// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects six interrupt sources and presents a CPU with one request and a 16-bit vector address. Each source can be enabled on its own, all of them can be masked by one global enable, and each source is placed on one of two priority levels by its own priority bit. Within a level, a fixed polling order breaks ties. The serial request is the OR of a receive flag and a transmit flag. The timer 2 request is the OR of an overflow flag and an external-event flag.

The controller tracks which levels are in service, so interrupts nest. A high-level request may interrupt a running low-level handler. Nothing interrupts a high-level handler, and a low-level request never interrupts another low-level handler. The CPU takes a request by pulsing `ack` while `irq_req` is high, and it ends a handler by pulsing `reti`. Taking a timer 0 or timer 1 vector produces a one-cycle clear pulse toward that source's flag. The serial and timer 2 flags are left for software to clear. The source flags are inputs, so a flag that software sets raises a request, and a flag that software clears withdraws a request that has not yet been taken.

Configuration uses one 8-bit write port with two targets, the enable register and the priority register. All outputs are registered.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_req` and `clr_pulse` are 0, and every enable, priority and in-service bit is 0.
- R2: Sources are indexed ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4, timer2=5. The vector of index i is 0x0003 + 8*i, which gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B.
- R3: When several eligible sources share a level, the one with the lowest index is requested.
- R4: An eligible high-level source is requested ahead of any low-level source, whatever its index. `irq_level` reports the level of the request (1 = high).
- R5: A write with `cfg_sel`=0 loads the enable register. Bit 7 is the global enable and bits 5:0 are the per-source enables in index order. A write with `cfg_sel`=1 loads the priority register, where bits 5:0 are the priority bits in index order and 1 means high. While the global enable is 0, no request is made.
- R6: While a high-level handler is in service, no request is made. While only a low-level handler is in service, only high-level sources are requested.
- R7: A `reti` pulse clears the high in-service bit if it is set, and otherwise clears the low in-service bit.
- R8: The serial request is `src_rx` OR `src_tx`, and the timer 2 request is `src_t2ovf` OR `src_t2ext`. Taking either of these vectors produces no clear pulse.
- R9: Taking the tmr0 (index 1) or tmr1 (index 3) vector sets bit 1 or bit 3 of `clr_pulse`, respectively, for exactly the one cycle after the cycle in which the request was accepted.
- R10: `irq_req` is registered. A change to a flag or to a configuration register shows at the output two edges later at most. In the cycle after an accepted `ack`, or after a `reti`, `irq_req` is 0.
- R11: If a source flag drops before its request is taken, the request is withdrawn and no in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ext0 | input | 1 | External request 0 flag |
| src_tmr0 | input | 1 | Timer 0 overflow flag |
| src_ext1 | input | 1 | External request 1 flag |
| src_tmr1 | input | 1 | Timer 1 overflow flag |
| src_rx | input | 1 | Serial receive flag |
| src_tx | input | 1 | Serial transmit flag |
| src_t2ovf | input | 1 | Timer 2 overflow flag |
| src_t2ext | input | 1 | Timer 2 external-event flag |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = enable register, 1 = priority register |
| cfg_wdata | input | 8 | Configuration write data |
| ack | input | 1 | CPU takes the presented request |
| reti | input | 1 | CPU return-from-interrupt pulse |
| irq_req | output | 1 | Request to the CPU |
| irq_level | output | 1 | Level of the presented request |
| irq_vec | output | 16 | Vector address of the presented request |
| clr_pulse | output | 6 | Per-source auto-clear pulse |

## Verification
The bench goes after the nesting rules first. A tracker that lets a low-level request preempt a low-level handler would show a second request while the first handler is still running. A tracker that pops the wrong level on `reti` would hold back a high-level request that should now appear.

The cycle right after `ack` is checked separately, because a controller that does not blank the output there would present a stale request that the CPU could take a second time. The bench also covers these cases:
- a serial or timer 2 vector that wrongly produces a clear pulse;
- a request that is still made while the global enable is off;
- a high-level source at a high index that loses to a low-level source at a lower index.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int SRC_COUNT = 6;

  typedef enum logic {
    CFG_ENABLE   = 1'b0,
    CFG_PRIORITY = 1'b1
  } cfg_target_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } nest_state_t;

  function automatic logic [15:0] vector_of(input int idx, input int base, input int stride);
    int v;
    v = base + stride * idx;
    return v[15:0];
  endfunction

endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs #(
  parameter int NUM_SRC  = 6,
  parameter int DATA_W   = 8,
  parameter int GLOB_BIT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] src_en,
  output logic [NUM_SRC-1:0] src_pri,
  output logic               glob_en
);
  import irqc_pkg::*;

  cfg_target_e target;
  assign target = cfg_target_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en  <= '0;
      src_pri <= '0;
      glob_en <= 1'b0;
    end else if (we) begin
      case (target)
        CFG_ENABLE: begin
          src_en  <= wdata[NUM_SRC-1:0];
          glob_en <= wdata[GLOB_BIT];
        end
        CFG_PRIORITY: src_pri <= wdata[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 6,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] pri,
  input  irqc_pkg::nest_state_t nest,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic               win_lvl
);
  logic [NUM_SRC-1:0] elig_hi;
  logic [NUM_SRC-1:0] elig_lo;
  logic               open_hi;
  logic               open_lo;

  assign open_hi = !nest.hi;
  assign open_lo = !nest.hi && !nest.lo;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig_hi[i] = pend[i] &&  pri[i] && open_hi;
    assign elig_lo[i] = pend[i] && !pri[i] && open_lo;
  end

  logic [IDX_W-1:0] idx_hi;
  logic [IDX_W-1:0] idx_lo;

  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig_hi[i]) idx_hi = IDX_W'(i);
      if (elig_lo[i]) idx_lo = IDX_W'(i);
    end
  end

  always_comb begin
    if (|elig_hi) begin
      win_valid = 1'b1;
      win_idx   = idx_hi;
      win_lvl   = 1'b1;
    end else if (|elig_lo) begin
      win_valid = 1'b1;
      win_idx   = idx_lo;
      win_lvl   = 1'b0;
    end else begin
      win_valid = 1'b0;
      win_idx   = '0;
      win_lvl   = 1'b0;
    end
  end
endmodule

// File: rtl/irqc_nest_tracker.sv
module irqc_nest_tracker (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_lvl,
  input  logic reti,
  output irqc_pkg::nest_state_t nest
);
  logic pop_hi;
  logic pop_lo;

  assign pop_hi = reti && nest.hi;
  assign pop_lo = reti && !nest.hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      nest.hi <= 1'b0;
      nest.lo <= 1'b0;
    end else begin
      nest.hi <= (nest.hi && !pop_hi) || (take &&  take_lvl);
      nest.lo <= (nest.lo && !pop_lo) || (take && !take_lvl);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int DATA_W     = 8,
  parameter int GLOB_BIT   = 7,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [irqc_pkg::SRC_COUNT-1:0] AUTOCLR_MASK = 6'b001010,
  localparam int NUM_SRC   = irqc_pkg::SRC_COUNT,
  localparam int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_ext0,
  input  logic               src_tmr0,
  input  logic               src_ext1,
  input  logic               src_tmr1,
  input  logic               src_rx,
  input  logic               src_tx,
  input  logic               src_t2ovf,
  input  logic               src_t2ext,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               ack,
  input  logic               reti,
  output logic               irq_req,
  output logic               irq_level,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [NUM_SRC-1:0] clr_pulse
);
  import irqc_pkg::*;

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] src_pri;
  logic               glob_en;
  logic [NUM_SRC-1:0] pend;
  nest_state_t        nest;
  logic               nest_hi;
  logic               nest_lo;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic               win_lvl;
  logic [IDX_W-1:0]   irq_idx;
  logic               take;

  assign flags = {src_t2ovf | src_t2ext, src_rx | src_tx,
                  src_tmr1, src_ext1, src_tmr0, src_ext0};
  assign pend    = flags & src_en & {NUM_SRC{glob_en}};
  assign take    = ack && irq_req;
  assign nest_hi = nest.hi;
  assign nest_lo = nest.lo;

  irqc_cfg_regs #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .GLOB_BIT(GLOB_BIT)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .src_en (src_en),
    .src_pri(src_pri),
    .glob_en(glob_en)
  );

  irqc_arbiter #(
    .NUM_SRC(NUM_SRC)
  ) u_arb (
    .pend     (pend),
    .pri      (src_pri),
    .nest     (nest),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  irqc_nest_tracker u_nest (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_lvl(irq_level),
    .reti    (reti),
    .nest    (nest)
  );

  logic [NUM_SRC-1:0] take_onehot;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign take_onehot[i] = take && (irq_idx == IDX_W'(i)) && AUTOCLR_MASK[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_level <= 1'b0;
      irq_vec   <= '0;
      irq_idx   <= '0;
      clr_pulse <= '0;
    end else begin
      clr_pulse <= take_onehot;
      irq_req   <= win_valid && !take && !reti;
      if (win_valid) begin
        irq_idx   <= win_idx;
        irq_level <= win_lvl;
        irq_vec   <= VEC_W'(vector_of(int'(win_idx), VEC_BASE, VEC_STRIDE));
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_SRC    = 6,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [NUM_SRC-1:0] AUTOCLR_MASK = 6'b001010
) (
  input logic               clk,
  input logic               rst,
  input logic               ack,
  input logic               reti,
  input logic               irq_req,
  input logic               irq_level,
  input logic [VEC_W-1:0]   irq_vec,
  input logic [NUM_SRC-1:0] clr_pulse,
  input logic               glob_en,
  input logic               nest_hi,
  input logic               nest_lo
);
  AST_NO_REQ_UNDER_HI: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !nest_hi); // R6

  AST_LOW_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (irq_req && nest_lo) |-> irq_level); // R6

  AST_BLANK_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (irq_req && ack) |=> !irq_req); // R10

  AST_BLANK_AFTER_RETI: assert property (@(posedge clk) disable iff (rst)
    reti |=> !irq_req); // R10

  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(glob_en)); // R5

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (int'(irq_vec) >= VEC_BASE &&
                 (int'(irq_vec) - VEC_BASE) % VEC_STRIDE == 0 &&
                 int'(irq_vec) <= VEC_BASE + VEC_STRIDE * (NUM_SRC - 1))); // R2

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_pulse) && ((clr_pulse & ~AUTOCLR_MASK) == '0)); // R8

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr_chk
    AST_CLR_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
      clr_pulse[i] |-> $past(irq_req && ack &&
                             int'(irq_vec) == VEC_BASE + VEC_STRIDE * i)); // R9
  end
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_SRC     (NUM_SRC),
  .VEC_W       (VEC_W),
  .VEC_BASE    (VEC_BASE),
  .VEC_STRIDE  (VEC_STRIDE),
  .AUTOCLR_MASK(AUTOCLR_MASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack      (ack),
  .reti     (reti),
  .irq_req  (irq_req),
  .irq_level(irq_level),
  .irq_vec  (irq_vec),
  .clr_pulse(clr_pulse),
  .glob_en  (glob_en),
  .nest_hi  (nest_hi),
  .nest_lo  (nest_lo)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_ext0 = 0, src_tmr0 = 0, src_ext1 = 0, src_tmr1 = 0;
  logic src_rx = 0, src_tx = 0, src_t2ovf = 0, src_t2ext = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 8'h00;
  logic ack = 0, reti = 0;
  logic irq_req, irq_level;
  logic [15:0] irq_vec;
  logic [5:0] clr_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst(rst),
    .src_ext0(src_ext0), .src_tmr0(src_tmr0), .src_ext1(src_ext1), .src_tmr1(src_tmr1),
    .src_rx(src_rx), .src_tx(src_tx), .src_t2ovf(src_t2ovf), .src_t2ext(src_t2ext),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec), .clr_pulse(clr_pulse)
  );

  // Behavioural reference model
  bit [5:0] m_en, m_pri, m_clr;
  bit m_glob, m_hi, m_lo, m_req, m_lvl;
  int m_vec;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_pri = 0; m_glob = 0; m_hi = 0; m_lo = 0;
      m_req = 0; m_lvl = 0; m_vec = 0; m_clr = 0;
    end else begin
      bit [5:0] f;
      int best, blv, tidx;
      bit took;
      f = {src_t2ovf | src_t2ext, src_rx | src_tx, src_tmr1, src_ext1, src_tmr0, src_ext0};
      best = -1; blv = 0;
      for (int lv = 1; lv >= 0; lv--)
        for (int i = 0; i < 6; i++)
          if (best < 0 && f[i] && m_en[i] && m_glob && int'(m_pri[i]) == lv &&
              (lv == 1 ? !m_hi : (!m_hi && !m_lo))) begin
            best = i; blv = lv;
          end
      took = ack && m_req;
      m_clr = 0;
      if (took) begin
        tidx = (m_vec - 3) / 8;
        if (tidx == 1 || tidx == 3) m_clr[tidx] = 1;
      end
      if (reti) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end
      if (took) begin
        if (m_lvl) m_hi = 1; else m_lo = 1;
      end
      if (best >= 0) begin
        m_vec = 3 + 8 * best; m_lvl = blv[0];
      end
      m_req = (best >= 0) && !took && !reti;
      if (cfg_we) begin
        if (!cfg_sel) begin m_en = cfg_wdata[5:0]; m_glob = cfg_wdata[7]; end
        else m_pri = cfg_wdata[5:0];
      end
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq_req !== m_req) begin
        errors++;
        $display("FAIL R6 irq_req act=%0b exp=%0b t=%0t", irq_req, m_req, $time);
      end
      if (m_req && (irq_vec !== m_vec[15:0] || irq_level !== m_lvl)) begin
        errors++;
        $display("FAIL R2 vec/level act=%h/%0b exp=%h/%0b", irq_vec, irq_level, m_vec[15:0], m_lvl);
      end
      if (clr_pulse !== m_clr) begin
        errors++;
        $display("FAIL R9 clr_pulse act=%b exp=%b", clr_pulse, m_clr);
      end
    end
  end

  // Flag sources clear timer flags on their clear pulse
  always @(negedge clk) begin
    if (clr_pulse[1]) src_tmr0 = 0;
    if (clr_pulse[3]) src_tmr1 = 0;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(input bit sel, input logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; cyc(1); ack = 0;
  endtask

  task automatic pulse_reti();
    reti = 1; cyc(1); reti = 0;
  endtask

  task automatic expect_req(input bit er, input logic [15:0] ev, input string req);
    checks++;
    if (irq_req !== er || (er && irq_vec !== ev)) begin
      errors++;
      $display("FAIL %s req/vec act=%0b/%h exp=%0b/%h", req, irq_req, irq_vec, er, ev);
    end
  endtask

  initial begin
    cyc(3);
    // R1: reset state
    checks++;
    if (irq_req !== 0 || clr_pulse !== 0) begin
      errors++;
      $display("FAIL R1 reset act=%0b/%b exp=0/000000", irq_req, clr_pulse);
    end
    rst = 0;
    cyc(2);

    // R5: global enable off masks everything
    wcfg(0, 8'h3F);
    src_t2ext = 1;
    cyc(3);
    expect_req(0, 16'h0, "R5");
    wcfg(0, 8'hBF);
    cyc(2);
    expect_req(1, 16'h002B, "R8");            // timer2 via external flag
    // R8: take timer2, no clear pulse; R10 blank cycle
    pulse_ack();
    expect_req(0, 16'h0, "R10");
    checks++;
    if (clr_pulse !== 6'b0) begin errors++; $display("FAIL R8 clr act=%b exp=000000", clr_pulse); end
    // R6: low in service, low ext0 cannot preempt
    src_ext0 = 1;
    cyc(3);
    expect_req(0, 16'h0, "R6");
    // R4: ext0 moved to high level preempts
    wcfg(1, 8'h01);
    cyc(2);
    expect_req(1, 16'h0003, "R4");
    pulse_ack();
    src_ext0 = 0;
    // R6: high in service, high tmr0 blocked
    wcfg(1, 8'h03);
    src_tmr0 = 1;
    cyc(3);
    expect_req(0, 16'h0, "R6");
    // R7: reti pops the high level, tmr0 now allowed
    pulse_reti();
    expect_req(0, 16'h0, "R10");
    cyc(1);
    expect_req(1, 16'h000B, "R7");
    pulse_ack();
    // R9: clear pulse for tmr0 in this cycle
    checks++;
    if (clr_pulse !== 6'b000010) begin errors++; $display("FAIL R9 clr act=%b exp=000010", clr_pulse); end
    cyc(1);
    pulse_reti();
    pulse_reti();
    src_t2ext = 0;
    cyc(2);
    expect_req(0, 16'h0, "R7");

    // R3: same level, lowest index wins
    wcfg(1, 8'h00);
    src_tmr1 = 1; src_ext1 = 1;
    cyc(3);
    expect_req(1, 16'h0013, "R3");
    // R4: high-level timer2 over low-level ext1
    wcfg(1, 8'h20);
    src_t2ovf = 1;
    cyc(3);
    expect_req(1, 16'h002B, "R4");
    src_t2ovf = 0;
    src_ext1 = 0;
    cyc(3);
    expect_req(1, 16'h001B, "R3");
    pulse_ack();
    cyc(2);
    pulse_reti();
    cyc(2);
    // R8: serial from rx then tx
    src_rx = 1;
    cyc(3);
    expect_req(1, 16'h0023, "R8");
    src_rx = 0; src_tx = 1;
    cyc(3);
    expect_req(1, 16'h0023, "R8");
    // R11: withdrawing flag cancels, no in-service
    src_tx = 0;
    cyc(3);
    expect_req(0, 16'h0, "R11");
    src_ext0 = 1;
    cyc(3);
    expect_req(1, 16'h0003, "R11");
    src_ext0 = 0;
    cyc(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      done = 1;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule